// File: doc/BRIEF.md
# Display Frame Burst Sequencer

This block drives the refill of a display FIFO for one video frame. It rests until a frame tick arrives, which comes once every 20 ms (a 50 Hz frame rate). On a tick it gives the FIFO a one-clock clear pulse. It then steps through a fixed number of DMA bursts. For each burst it latches a readout control byte and fires a start strobe. After a burst has been fully taken in by the FIFO, the sequencer moves to the next burst on its own, with no help from the host. When the last burst has been accepted, it returns to rest and waits for the next tick.

The control byte for each burst comes from an outside source. The sequencer addresses that source with its current burst number, which it drives on `burst_sel`. The DMA engine uses `burst_go` to start a transfer and reports completion on `burst_accepted`. A tick that arrives while a frame is still being sequenced is ignored and reported on `tick_overrun`.

Top module: `frame_burst_seq`

## Requirements
- R1: While reset is asserted, `fifo_clear`, `burst_go`, `tick_overrun`, `burst_sel` and `ctrl_byte` are all 0.
- R2: A `frame_tick` sampled while the sequencer is at rest raises `fifo_clear` for exactly one cycle, starting in the next cycle. `fifo_clear` never rises without a tick in the previous cycle.
- R3: The first `burst_go` of a frame comes exactly two cycles after `fifo_clear`. `burst_go` is always a single-cycle pulse. In every cycle where `burst_go` is high, `ctrl_byte` already holds the value `ctrl_src` had in the previous cycle.
- R4: A `burst_accepted` pulse taken while a burst is outstanding, and which is not for the last burst, does two things. It raises `burst_sel` by one in the next cycle. It produces the next `burst_go` two cycles after the pulse.
- R5: Each frame yields exactly `NUM_BURSTS` start strobes. Once the last burst is accepted, no `burst_go` and no `fifo_clear` occur until the next tick.
- R6: A `frame_tick` sampled while a frame is in progress raises `tick_overrun` for one cycle, starting in the next cycle. It produces no `fifo_clear`, and the running frame carries on unchanged.
- R7: A `burst_accepted` pulse while no burst is outstanding has no effect on `burst_go`, `burst_sel` or `ctrl_byte`.
- R8: `burst_sel` reads 0 from the cycle after `fifo_clear` until the first acceptance. It never exceeds `NUM_BURSTS-1`.
- R9: `ctrl_byte` changes only in a cycle where `burst_go` is high. Between bursts and after the frame ends, it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_tick | input | 1 | Frame-rate tick, one cycle wide |
| burst_accepted | input | 1 | Pulse: the outstanding burst has been fully taken in by the FIFO |
| ctrl_src | input | CTRL_W | Control byte for the burst addressed by `burst_sel` |
| burst_sel | output | IDX_W | Current burst number within the frame |
| fifo_clear | output | 1 | One-cycle FIFO clear at the start of a frame |
| ctrl_byte | output | CTRL_W | Latched readout control byte |
| burst_go | output | 1 | One-cycle burst start strobe |
| tick_overrun | output | 1 | One-cycle flag: a tick arrived during a frame and was dropped |

## Verification
The hardest cases to reach from the ports are two stray inputs. One is a frame tick that lands while a burst is still outstanding. The other is an acceptance pulse that arrives while nothing is outstanding. Both must be absorbed without changing the sequence of control bytes.

The stimulus produces them on purpose. It waits for a start strobe, lets one cycle pass so the sequencer is waiting for acceptance, and then injects the tick. Separately, it pulses acceptance after a frame has finished. A queue-based scoreboard confirms that the byte sequence and the strobe count are still unchanged. The acceptance delay also varies from burst to burst, so that the chaining timing is exercised at more than one spacing.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLEAR  = 3'd1,
    ST_LOAD   = 3'd2,
    ST_START  = 3'd3,
    ST_WAIT   = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic burst_accepted,
  input  logic last_burst,
  output logic fifo_clear,
  output logic load_en,
  output logic burst_go,
  output logic idx_clr,
  output logic idx_inc,
  output logic tick_overrun
);

  seq_state_e state_q, state_d;
  logic       ovr_q, ovr_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (frame_tick) state_d = ST_CLEAR;
      ST_CLEAR: state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_START;
      ST_START: state_d = ST_WAIT;
      ST_WAIT:  if (burst_accepted) state_d = last_burst ? ST_DONE : ST_LOAD;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign ovr_d = frame_tick && (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ovr_q   <= ovr_d;
    end
  end

  assign fifo_clear   = (state_q == ST_CLEAR);
  assign load_en      = (state_q == ST_LOAD);
  assign burst_go     = (state_q == ST_START);
  assign idx_clr      = (state_q == ST_CLEAR);
  assign idx_inc      = (state_q == ST_WAIT) && burst_accepted && !last_burst;
  assign tick_overrun = ovr_q;

  p_clear_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> !fifo_clear);

  p_clear_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_clear) |-> $past(frame_tick));

  p_go_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_go |=> !burst_go);

  p_overrun_no_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_overrun |-> !fifo_clear);

endmodule

// File: rtl/seq_burst_ctr.sv
module seq_burst_ctr #(
  parameter int NUM_BURSTS = 4,
  localparam int IDX_W = (NUM_BURSTS > 1) ? $clog2(NUM_BURSTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_clr,
  input  logic             idx_inc,
  output logic [IDX_W-1:0] idx,
  output logic             last_burst
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BURSTS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign idx_en = idx_clr || idx_inc;
  assign idx_d  = idx_clr ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx        = idx_q;
  assign last_burst = (idx_q == LAST_IDX);

  p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

endmodule

// File: rtl/seq_ctrl_latch.sv
module seq_ctrl_latch #(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CTRL_W-1:0] ctrl_src,
  output logic [CTRL_W-1:0] ctrl_byte
);

  logic [CTRL_W-1:0] byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (load_en) byte_q <= ctrl_src;
  end

  assign ctrl_byte = byte_q;

endmodule

// File: rtl/frame_burst_seq.sv
module frame_burst_seq #(
  parameter int NUM_BURSTS = 4,
  parameter int CTRL_W     = 8,
  localparam int IDX_W = (NUM_BURSTS > 1) ? $clog2(NUM_BURSTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              burst_accepted,
  input  logic [CTRL_W-1:0] ctrl_src,
  output logic [IDX_W-1:0]  burst_sel,
  output logic              fifo_clear,
  output logic [CTRL_W-1:0] ctrl_byte,
  output logic              burst_go,
  output logic              tick_overrun
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       load_en, idx_clr, idx_inc, last_burst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .frame_tick     (frame_tick),
    .burst_accepted (burst_accepted),
    .last_burst     (last_burst),
    .fifo_clear     (fifo_clear),
    .load_en        (load_en),
    .burst_go       (burst_go),
    .idx_clr        (idx_clr),
    .idx_inc        (idx_inc),
    .tick_overrun   (tick_overrun)
  );

  seq_burst_ctr #(.NUM_BURSTS(NUM_BURSTS)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .idx_clr    (idx_clr),
    .idx_inc    (idx_inc),
    .idx        (burst_sel),
    .last_burst (last_burst)
  );

  seq_ctrl_latch #(.CTRL_W(CTRL_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_en   (load_en),
    .ctrl_src  (ctrl_src),
    .ctrl_byte (ctrl_byte)
  );

  p_latch_fresh_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    burst_go |-> (ctrl_byte == $past(ctrl_src)));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(ctrl_byte) |-> burst_go);

  p_sel_zero_after_clear_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    fifo_clear |=> (burst_sel == '0));

endmodule

// File: tb/sim_frame_burst_seq.sv
module sim_frame_burst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 4;
  localparam int CW  = 8;
  localparam int IW  = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_tick;
  logic          burst_accepted;
  logic [CW-1:0] ctrl_src;
  logic [IW-1:0] burst_sel;
  logic          fifo_clear;
  logic [CW-1:0] ctrl_byte;
  logic          burst_go;
  logic          tick_overrun;
  logic [CW-1:0] seed;

  int n_checks = 0;
  int n_fail   = 0;
  int go_count = 0;
  logic [CW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ctrl_src = seed + CW'(burst_sel) * 8'd37;

  frame_burst_seq #(.NUM_BURSTS(NB), .CTRL_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .burst_accepted(burst_accepted), .ctrl_src(ctrl_src),
    .burst_sel(burst_sel), .fifo_clear(fifo_clear), .ctrl_byte(ctrl_byte),
    .burst_go(burst_go), .tick_overrun(tick_overrun)
  );

  function automatic logic [CW-1:0] exp_byte(logic [CW-1:0] s, int i);
    return s + CW'(i) * 8'd37;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops one expected byte per start strobe
  always @(negedge clk) begin
    if (rst_n && burst_go) begin
      go_count++;
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected burst_go", 1, 0);
      end else begin
        logic [CW-1:0] e;
        e = exp_q.pop_front();
        chk(ctrl_byte == e, "R3/R4 ctrl_byte at burst_go", ctrl_byte, e);
      end
    end
  end

  // Driver: pushes the expected bytes, runs one frame
  task automatic run_frame(input logic [CW-1:0] s, input bit inject_tick);
    int g0;
    seed = s;
    for (int i = 0; i < NB; i++) exp_q.push_back(exp_byte(s, i));
    g0 = go_count;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    chk(fifo_clear == 1'b1, "R2 clear after tick", fifo_clear, 1);
    @(negedge clk);
    chk(fifo_clear == 1'b0, "R2 clear one cycle", fifo_clear, 0);
    chk(burst_sel == 0, "R8 sel zero after clear", burst_sel, 0);
    @(negedge clk);
    chk(burst_go == 1'b1, "R3 first go two cycles after clear", burst_go, 1);
    for (int b = 1; b < NB; b++) begin
      @(negedge clk);
      chk(burst_go == 1'b0, "R3 go single cycle", burst_go, 0);
      if (inject_tick && b == 1) begin
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        chk(tick_overrun == 1'b1, "R6 overrun flagged", tick_overrun, 1);
        chk(fifo_clear == 1'b0, "R6 no clear on overrun", fifo_clear, 0);
      end
      repeat (b % 3) @(negedge clk);
      burst_accepted = 1'b1;
      @(negedge clk);
      burst_accepted = 1'b0;
      chk(burst_sel == b, "R4 sel increments", burst_sel, b);
      chk(burst_go == 1'b0, "R4 no go one cycle after accept", burst_go, 0);
      @(negedge clk);
      chk(burst_go == 1'b1, "R4 go two cycles after accept", burst_go, 1);
    end
    repeat (2) @(negedge clk);
    burst_accepted = 1'b1;
    @(negedge clk);
    burst_accepted = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(burst_go == 1'b0 && fifo_clear == 1'b0, "R5 quiet after last burst",
          {burst_go, fifo_clear}, 0);
    end
    chk(go_count - g0 == NB, "R5 strobes per frame", go_count - g0, NB);
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    chk(ctrl_byte == exp_byte(s, NB-1), "R9 latch holds last byte", ctrl_byte,
        exp_byte(s, NB-1));
    chk(burst_sel == NB-1, "R8 sel bounded", burst_sel, NB-1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    frame_tick = 1'b0;
    burst_accepted = 1'b0;
    seed = 8'h00;
    repeat (3) @(negedge clk);
    chk(fifo_clear == 0 && burst_go == 0 && tick_overrun == 0, "R1 reset outputs",
        {fifo_clear, burst_go, tick_overrun}, 0);
    chk(burst_sel == 0 && ctrl_byte == 0, "R1 reset sel and byte",
        {burst_sel, ctrl_byte}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    run_frame(8'h10, 1'b0);
    run_frame(8'h5A, 1'b1);

    // R7: stray acceptance while at rest
    begin
      logic [CW-1:0] held;
      logic [IW-1:0] sel_held;
      held = ctrl_byte;
      sel_held = burst_sel;
      burst_accepted = 1'b1;
      @(negedge clk);
      burst_accepted = 1'b0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(burst_go == 1'b0, "R7 stray accept no go", burst_go, 0);
      end
      chk(ctrl_byte == held, "R7 stray accept byte kept", ctrl_byte, held);
      chk(burst_sel == sel_held, "R7 stray accept sel kept", burst_sel, sel_held);
    end

    run_frame(8'hC3, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule